// File: doc/BRIEF.md
# Flash Block Lock Protection Register

This block holds the per-block write-protection state of an embedded flash controller in one 32-bit register. The register has one lock bit for each block of a low address region and of a mid address region, plus one lock bit for a small test region. Each lock bit is combined with two sideband vectors that arrive from outside, one for program protection and one for erase protection. The result is a pair of effective-protection vectors: a block is protected when either its own lock bit or the matching sideband bit is set.

Program and erase requests reach the block on a valid/ready stream. Each request carries an operation code and a 5-bit block index. A request to an unprotected block passes unchanged to the downstream command stream, and back-pressure from that stream goes straight back to the requester. A request to a protected block is consumed at once without being forwarded, and the program/erase error flag is set. Software access to the register is frozen while an interlock write awaits completion and while a high-voltage operation is suspended.

Bit layout: bit 31 is the test-region lock. Bit 30 is reserved. Bits [LOW_N-1:0] are the low-region locks, and bits [LOW_N+MID_N-1:LOW_N] are the mid-region locks. Parameter masks say which low and mid positions exist. A sideband bit index equals the register bit index, and a request's block index also uses this bit numbering.

Top module: `flk_lock_ctrl`

## Requirements
- R1: After reset, every register bit reads 1 except reserved bit 30, which reads 0 (32'hBFFFFFFF when LOW_N+MID_N is 30), and the error flag `peg` is 0.
- R2: A write with `bus_addr` equal to LOCK_OFFSET (default 8'h10), when not frozen, loads the existing lock bits from `bus_wdata`. The new value is visible on `bus_rdata` from the cycle after the write edge. `bus_rdata` is 0 for any other address, and writes to other addresses change nothing.
- R3: Bit 30 ignores writes and always reads 0.
- R4: Lock positions that the presence masks mark absent always read 1, whatever is written.
- R5: `eff_prog_lock[i]` is the register bit OR `prog_side[i]` for each existing block. It is 1 for absent positions and for bit 30. Bit 31 is the test lock OR `prog_side[31]`.
- R6: `eff_erase_lock[i]` is the register bit OR `erase_side[i]` for each existing block. It is 1 for absent positions, for bit 30 and for bit 31, because the test region is never erasable.
- R7: Register writes are ignored in any cycle where `hv_suspend` is 1.
- R8: Register writes are ignored from the cycle that `ilk_wr_done` pulses. They stay ignored up to and including the first later cycle in which `pe_done` is 1. A write in the cycle after that is accepted.
- R9: A request is blocked when its target is protected: bit `req_blk` of `eff_erase_lock` when `req_op` is 1 (erase), or of `eff_prog_lock` when `req_op` is 0 (program). A blocked request sees `req_ready`=1 and `cmd_valid`=0 in the same cycle. Any other request sees `cmd_valid`=`req_valid` and `req_ready`=`cmd_ready`, and `cmd_op`/`cmd_blk` always mirror `req_op`/`req_blk`.
- R10: `peg` becomes 1 the cycle after a blocked request is presented and stays 1. It returns to 0 the cycle after a request is accepted downstream (`cmd_valid` and `cmd_ready` both 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from the address) |
| ilk_wr_done | input | 1 | Pulse: an interlock write has completed |
| pe_done | input | 1 | Level: the program/erase sequence has finished |
| hv_suspend | input | 1 | Level: a high-voltage operation is suspended |
| prog_side | input | 32 | Program-lock sideband vector |
| erase_side | input | 32 | Erase-lock sideband vector |
| eff_prog_lock | output | 32 | Effective program protection per bit position |
| eff_erase_lock | output | 32 | Effective erase protection per bit position |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_op | input | 1 | Request operation: 0 program, 1 erase |
| req_blk | input | 5 | Request block index (register bit numbering) |
| cmd_valid | output | 1 | Forwarded command valid |
| cmd_ready | input | 1 | Downstream ready |
| cmd_op | output | 1 | Forwarded operation |
| cmd_blk | output | 5 | Forwarded block index |
| peg | output | 1 | Sticky program/erase error flag |

## Verification
Read data, both effective-lock vectors and the request handshake are combinational. They are due in the same cycle as the stimulus. The bench drives inputs just after the falling edge and samples these outputs 1 ns later. A register write and the error flag each go through one flop, so their effect is due one cycle after the rising edge that samples the stimulus. The bench's reference model advances only at that edge and is compared on the following cycle. The freeze window (R8) is checked by writing in the pulse cycle, in the cycles while the window is open and in the cycle where `pe_done` rises, then confirming that the next write is taken.

// File: rtl/flk_pkg.sv
package flk_pkg;
  localparam int REG_W    = 32;
  localparam int BLK_W    = 5;
  localparam int TEST_BIT = 31;
  localparam int RSVD_BIT = 30;
  localparam int USABLE   = 30;

  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } flk_op_e;
endpackage

// File: rtl/flk_lock_store.sv
module flk_lock_store
  import flk_pkg::*;
#(
  parameter logic [USABLE-1:0] EXIST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             ilk_wr_done,
  input  logic             pe_done,
  input  logic             hv_suspend,
  output logic [REG_W-1:0] lock_view
);
  logic pend_q;
  logic frozen;
  logic wr_ok;
  logic unused_wbits;

  // Freeze includes the pulse cycle itself and the suspend level.
  assign frozen = ilk_wr_done | pend_q | hv_suspend;
  assign wr_ok  = wr_en & ~frozen;
  assign unused_wbits = ^{wdata[RSVD_BIT], wdata[USABLE-1:0] & ~EXIST};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pend_q <= 1'b0;
    else if (ilk_wr_done) pend_q <= 1'b1;
    else if (pe_done)     pend_q <= 1'b0;
  end

  for (genvar i = 0; i < USABLE; i++) begin : g_bit
    if (EXIST[i]) begin : g_ff
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= 1'b1;
        else if (wr_ok) q <= wdata[i];
      end
      assign lock_view[i] = q;
    end else begin : g_tie
      assign lock_view[i] = 1'b1;
    end
  end

  logic test_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     test_q <= 1'b1;
    else if (wr_ok) test_q <= wdata[TEST_BIT];
  end

  assign lock_view[TEST_BIT] = test_q;
  assign lock_view[RSVD_BIT] = 1'b0;
endmodule

// File: rtl/flk_protect.sv
module flk_protect
  import flk_pkg::*;
#(
  parameter logic [USABLE-1:0] EXIST = '1
) (
  input  logic [REG_W-1:0] lock_view,
  input  logic [REG_W-1:0] prog_side,
  input  logic [REG_W-1:0] erase_side,
  output logic [REG_W-1:0] eff_prog,
  output logic [REG_W-1:0] eff_erase
);
  logic unused_in;
  assign unused_in = ^{lock_view[RSVD_BIT], prog_side[RSVD_BIT],
                       erase_side[TEST_BIT], erase_side[RSVD_BIT],
                       lock_view[USABLE-1:0] & ~EXIST,
                       prog_side[USABLE-1:0] & ~EXIST,
                       erase_side[USABLE-1:0] & ~EXIST};

  for (genvar i = 0; i < USABLE; i++) begin : g_eff
    if (EXIST[i]) begin : g_live
      assign eff_prog[i]  = lock_view[i] | prog_side[i];
      assign eff_erase[i] = lock_view[i] | erase_side[i];
    end else begin : g_absent
      assign eff_prog[i]  = 1'b1;
      assign eff_erase[i] = 1'b1;
    end
  end

  assign eff_prog[RSVD_BIT]  = 1'b1;
  assign eff_erase[RSVD_BIT] = 1'b1;
  assign eff_prog[TEST_BIT]  = lock_view[TEST_BIT] | prog_side[TEST_BIT];
  assign eff_erase[TEST_BIT] = 1'b1;
endmodule

// File: rtl/flk_req_gate.sv
module flk_req_gate
  import flk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] eff_prog,
  input  logic [REG_W-1:0] eff_erase,
  input  logic             req_valid,
  output logic             req_ready,
  input  flk_op_e          req_op,
  input  logic [BLK_W-1:0] req_blk,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output flk_op_e          cmd_op,
  output logic [BLK_W-1:0] cmd_blk,
  output logic             peg
);
  logic blocked;

  always_comb begin
    if (req_op == OP_ERASE) blocked = eff_erase[req_blk];
    else                    blocked = eff_prog[req_blk];
  end

  assign cmd_valid = req_valid & ~blocked;
  assign req_ready = blocked | cmd_ready;
  assign cmd_op    = req_op;
  assign cmd_blk   = req_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      peg <= 1'b0;
    else if (req_valid && blocked)   peg <= 1'b1;
    else if (cmd_valid && cmd_ready) peg <= 1'b0;
  end
endmodule

// File: rtl/flk_lock_ctrl.sv
module flk_lock_ctrl
  import flk_pkg::*;
#(
  parameter int                LOW_N       = 14,
  parameter int                MID_N       = 16,
  parameter logic [LOW_N-1:0]  LOW_PRESENT = '1,
  parameter logic [MID_N-1:0]  MID_PRESENT = '1,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] LOCK_OFFSET = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ilk_wr_done,
  input  logic              pe_done,
  input  logic              hv_suspend,
  input  logic [31:0]       prog_side,
  input  logic [31:0]       erase_side,
  output logic [31:0]       eff_prog_lock,
  output logic [31:0]       eff_erase_lock,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [4:0]        req_blk,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_op,
  output logic [4:0]        cmd_blk,
  output logic              peg
);
  localparam logic [USABLE-1:0] EXIST_MAP = USABLE'({MID_PRESENT, LOW_PRESENT});

  logic             hit;
  logic [REG_W-1:0] lock_view;
  flk_op_e          cmd_op_e;

  assign hit       = (bus_addr == LOCK_OFFSET);
  assign bus_rdata = hit ? lock_view : '0;
  assign cmd_op    = cmd_op_e;

  flk_lock_store #(.EXIST(EXIST_MAP)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_wr & hit),
    .wdata      (bus_wdata),
    .ilk_wr_done(ilk_wr_done),
    .pe_done    (pe_done),
    .hv_suspend (hv_suspend),
    .lock_view  (lock_view)
  );

  flk_protect #(.EXIST(EXIST_MAP)) u_protect (
    .lock_view (lock_view),
    .prog_side (prog_side),
    .erase_side(erase_side),
    .eff_prog  (eff_prog_lock),
    .eff_erase (eff_erase_lock)
  );

  flk_req_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .eff_prog (eff_prog_lock),
    .eff_erase(eff_erase_lock),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_op   (flk_op_e'(req_op)),
    .req_blk  (req_blk),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_op   (cmd_op_e),
    .cmd_blk  (cmd_blk),
    .peg      (peg)
  );
endmodule

// File: rtl/flk_lock_ctrl_chk.sv
module flk_lock_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hit,
  input logic [31:0] bus_rdata,
  input logic [31:0] lock_view,
  input logic        ilk_wr_done,
  input logic        hv_suspend,
  input logic [31:0] prog_side,
  input logic [31:0] erase_side,
  input logic [31:0] eff_prog_lock,
  input logic [31:0] eff_erase_lock,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_op,
  input logic [4:0]  req_blk,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        peg
);
  AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (bus_rdata[30] == 1'b0)); // R3
  AST_PROG_SIDE_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_side & ~eff_prog_lock) == 32'h0); // R5
  AST_ERASE_SIDE_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_side & ~eff_erase_lock) == 32'h0); // R6
  AST_SUSPEND_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    hv_suspend |=> $stable(lock_view)); // R7
  AST_INTERLOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    ilk_wr_done |=> $stable(lock_view)); // R8
  AST_LOCKED_PROG_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_op && eff_prog_lock[req_blk]) |-> (!cmd_valid && req_ready)); // R9
  AST_LOCKED_ERASE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op && eff_erase_lock[req_blk]) |-> (!cmd_valid && req_ready)); // R9
  AST_PEG_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cmd_valid) |=> peg); // R10
  AST_PEG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !peg); // R10
endmodule

bind flk_lock_ctrl flk_lock_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .hit           (hit),
  .bus_rdata     (bus_rdata),
  .lock_view     (lock_view),
  .ilk_wr_done   (ilk_wr_done),
  .hv_suspend    (hv_suspend),
  .prog_side     (prog_side),
  .erase_side    (erase_side),
  .eff_prog_lock (eff_prog_lock),
  .eff_erase_lock(eff_erase_lock),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_op        (req_op),
  .req_blk       (req_blk),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .peg           (peg)
);

// File: tb/test_flk_lock_ctrl.sv
module test_flk_lock_ctrl;
  localparam int          LOW_N = 14;
  localparam int          MID_N = 16;
  localparam logic [13:0] LOW_P = 14'h3FFF;
  localparam logic [15:0] MID_P = 16'h0FFF;
  localparam logic [7:0]  OFF   = 8'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ilk_wr_done = 1'b0, pe_done = 1'b0, hv_suspend = 1'b0;
  logic [31:0] prog_side = '0, erase_side = '0;
  logic [31:0] eff_prog_lock, eff_erase_lock;
  logic        req_valid = 1'b0, req_op = 1'b0, cmd_ready = 1'b1;
  logic        req_ready, cmd_valid, cmd_op, peg;
  logic [4:0]  req_blk = '0, cmd_blk;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_reg = 32'hBFFF_FFFF;
  logic        m_pend = 1'b0;
  logic        m_peg = 1'b0;

  always #4 clk = ~clk;

  flk_lock_ctrl #(
    .LOW_N(LOW_N), .MID_N(MID_N), .LOW_PRESENT(LOW_P), .MID_PRESENT(MID_P),
    .ADDR_W(8), .LOCK_OFFSET(OFF)
  ) i_flk_lock_ctrl (.*);

  function automatic bit present(int i);
    if (i < LOW_N) return LOW_P[i];
    if (i < LOW_N + MID_N) return MID_P[i - LOW_N];
    return 1'b0;
  endfunction

  function automatic logic [31:0] fview(logic [31:0] w);
    logic [31:0] v;
    for (int i = 0; i < 30; i++) v[i] = present(i) ? w[i] : 1'b1;
    v[30] = 1'b0;
    v[31] = w[31];
    return v;
  endfunction

  function automatic logic [31:0] feff(logic [31:0] r, logic [31:0] s, bit erase);
    logic [31:0] v;
    for (int i = 0; i < 30; i++) v[i] = present(i) ? (r[i] | s[i]) : 1'b1;
    v[30] = 1'b1;
    v[31] = erase ? 1'b1 : (r[31] | s[31]);
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic idle();
    bus_addr = OFF; bus_wr = 1'b0; bus_wdata = '0;
    ilk_wr_done = 1'b0; pe_done = 1'b0; hv_suspend = 1'b0;
    prog_side = '0; erase_side = '0;
    req_valid = 1'b0; req_op = 1'b0; req_blk = '0; cmd_ready = 1'b1;
  endtask

  // Compare combinational outputs, advance the model across one rising edge.
  task automatic cycle();
    logic [31:0] ep, ee;
    logic blk;
    #1;
    ep  = feff(m_reg, prog_side, 1'b0);
    ee  = feff(m_reg, erase_side, 1'b1);
    blk = req_op ? ee[req_blk] : ep[req_blk];
    check("R2 rdata", bus_rdata, (bus_addr == OFF) ? m_reg : 32'h0);
    check("R5 eff_prog", eff_prog_lock, ep);
    check("R6 eff_erase", eff_erase_lock, ee);
    check("R9 handshake", {30'h0, cmd_valid, req_ready}, {30'h0, req_valid & ~blk, blk | cmd_ready});
    check("R9 passthru", {26'h0, cmd_op, cmd_blk}, {26'h0, req_op, req_blk});
    check("R10 peg", {31'h0, peg}, {31'h0, m_peg});
    if (bus_wr && bus_addr == OFF && !(ilk_wr_done | m_pend | hv_suspend)) m_reg = fview(bus_wdata);
    if (ilk_wr_done) m_pend = 1'b1;
    else if (pe_done) m_pend = 1'b0;
    if (req_valid && blk) m_peg = 1'b1;
    else if (req_valid && cmd_ready) m_peg = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [31:0] d);
    idle(); bus_wr = 1'b1; bus_wdata = d; cycle(); idle();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset value", bus_rdata, 32'hBFFF_FFFF);
    check("R1 reset peg", {31'h0, peg}, 32'h0);
    @(negedge clk);

    wr(32'h0000_0000);
    #1 check("R4 absent read one", bus_rdata, 32'h3C00_0000);
    cycle();
    wr(32'hFFFF_FFFF);
    #1 check("R3 reserved zero", bus_rdata, 32'hBFFF_FFFF);
    cycle();

    // R7: suspended write dropped
    idle(); hv_suspend = 1'b1; bus_wr = 1'b1; bus_wdata = 32'h0; cycle(); idle();
    #1 check("R7 suspend hold", bus_rdata, 32'hBFFF_FFFF);
    cycle();

    // R8: interlock window
    idle(); ilk_wr_done = 1'b1; bus_wr = 1'b1; cycle();
    idle(); bus_wr = 1'b1; cycle();
    idle(); bus_wr = 1'b1; pe_done = 1'b1; cycle(); idle();
    #1 check("R8 window hold", bus_rdata, 32'hBFFF_FFFF);
    wr(32'h0000_0000);
    #1 check("R8 reopened", bus_rdata, 32'h3C00_0000);

    // R9/R10: erase of the test region is always blocked
    idle(); req_valid = 1'b1; req_op = 1'b1; req_blk = 5'd31; cmd_ready = 1'b0;
    #1 check("R9 test erase blocked", {30'h0, cmd_valid, req_ready}, 32'h1);
    cycle(); idle();
    #1 check("R10 peg set", {31'h0, peg}, 32'h1);
    idle(); req_valid = 1'b1; req_op = 1'b0; req_blk = 5'd31; cycle(); idle();
    #1 check("R10 peg cleared", {31'h0, peg}, 32'h0);
    // R5: sideband bit 31 locks test programming
    idle(); prog_side = 32'h8000_0000; req_valid = 1'b1; req_blk = 5'd31;
    #1 check("R5 test side lock", {31'h0, cmd_valid}, 32'h0);
    cycle();

    for (int n = 0; n < 3000; n++) begin
      bus_addr    = ($urandom % 4 != 0) ? OFF : 8'($urandom);
      bus_wr      = ($urandom % 3 == 0);
      bus_wdata   = $urandom;
      ilk_wr_done = ($urandom % 20 == 0);
      pe_done     = ($urandom % 4 == 0);
      hv_suspend  = ($urandom % 10 == 0);
      prog_side   = ($urandom % 3 == 0) ? $urandom : 32'h0;
      erase_side  = ($urandom % 3 == 0) ? $urandom : 32'h0;
      req_valid   = ($urandom % 2 == 0);
      req_op      = 1'($urandom);
      req_blk     = 5'($urandom);
      cmd_ready   = ($urandom % 4 != 0);
      cycle();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule